// File: doc/BRIEF.md
# Two-level interrupt entry sequencer

This block sits beside a simple in-order core and decides, at each instruction boundary, whether the core must divert into one of two asynchronous interrupt handlers: a fast interrupt of higher priority and a normal interrupt of lower priority. It arbitrates the two level-sensitive requests against the mask bits of the current status. On entry it produces a one-cycle take pulse, the handler vector and the resume address. It also keeps the current status (mode, fast mask, normal mask) and a saved copy for each handler mode.

The core strobes `boundary_i` when an instruction retires and presents in `pc_i` the address of the next instruction. It strobes `eret_i` when a handler's return instruction retires. A return copies the saved status of the current handler mode back into the current status. The cycle right after a return is an evaluation point of its own. A request that was held off by the handler's masks is therefore taken there, with the restored return address as its resume address, before the interrupted instruction runs. The block never clears a request. A request stays pending until its source drops it.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the current status is mode 3 (privileged system mode) with both mask bits set. The saved status reads mode 0 with both masks clear, the return address reads 0 and `take_o` is low.
- R2: Requests are evaluated only in a cycle with `boundary_i` high or in the cycle right after an `eret_i` strobe. A request that is active in any other cycle causes no take.
- R3: The fast request is taken only when the fast mask is clear. The normal request is taken only when the normal mask is clear.
- R4: When both requests are pending and unmasked at the same evaluation point, the fast one is taken, with vector 0x1C.
- R5: A fast take raises `take_o` for one cycle in the cycle after the evaluation point. In that same cycle the current status reads mode 1 with both masks set. The fast bank holds the prior status, and the return address holds `pc_i` from the boundary cycle.
- R6: A normal take gives vector 0x18 and mode 2, sets the normal mask and leaves the fast mask unchanged. It saves the prior status and the resume address into the normal bank.
- R7: On `eret_i` the current status takes, in the next cycle, the saved status of the bank of the current mode. The fast bank is used in mode 1 and the normal bank in every other mode. The saved and return outputs always show that same bank.
- R8: A request that is unmasked by a return is taken in the cycle right after `eret_i` without a boundary strobe. Its resume address is the restored return address. After both handlers return, the return address reads the address interrupted first.
- R9: A fast take inside the normal handler keeps the normal bank intact. Returning from the fast handler restores the normal handler's status. Returning again restores the original status.
- R10: A request that drops before the next evaluation point is never taken.
- R11: A `boundary_i` strobe in the same cycle as `eret_i` is ignored, and evaluation moves to the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_req_i | input | 1 | Fast interrupt request, level |
| norm_req_i | input | 1 | Normal interrupt request, level |
| boundary_i | input | 1 | Instruction boundary strobe |
| eret_i | input | 1 | Exception return retired strobe |
| pc_i | input | AW | Address of the next instruction at a boundary |
| take_o | output | 1 | One-cycle exception entry pulse |
| vector_o | output | AW | Vector of the last entry |
| ret_addr_o | output | AW | Return address of the bank of the current mode |
| cur_mode_o | output | 2 | Current mode: 0 user, 1 fast, 2 normal, 3 system |
| cur_fmask_o | output | 1 | Current fast mask |
| cur_nmask_o | output | 1 | Current normal mask |
| sav_mode_o | output | 2 | Saved mode of the bank of the current mode |
| sav_fmask_o | output | 1 | Saved fast mask of that bank |
| sav_nmask_o | output | 1 | Saved normal mask of that bank |

## Verification
The bench goes after the simultaneous-request case. A design with the priority inverted would vector to 0x18 and leave the fast request waiting. It also holds a normal request through a fast handler and expects it taken in the cycle after the return, at the first interrupted address. A design that waits for a real boundary, or that resumes from `pc_i`, shows a late take or a wrong return address. A fast interrupt preempts the normal handler to expose a single shared save slot, which would lose the user status on the second return. Requests that drop before a boundary, and a boundary that coincides with a return, catch a design that latches requests or evaluates at the wrong cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_FAST = 2'd1,
    MODE_NORM = 2'd2,
    MODE_SYS  = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  fmask;
    logic  nmask;
  } stat_t;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_FAST = 2'd1,
    TAKE_NORM = 2'd2
  } take_e;

  localparam int NBANK     = 2;
  localparam int BANK_NORM = 0;
  localparam int BANK_FAST = 1;

  localparam stat_t RESET_STAT = '{mode: MODE_SYS, fmask: 1'b1, nmask: 1'b1};
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_seq_pkg::*;
(
  input  logic  eval_i,
  input  logic  fast_req_i,
  input  logic  norm_req_i,
  input  stat_t cur_i,
  output take_e pick_o
);
  always_comb begin
    pick_o = TAKE_NONE;
    if (eval_i) begin
      if (fast_req_i && !cur_i.fmask)      pick_o = TAKE_FAST;
      else if (norm_req_i && !cur_i.nmask) pick_o = TAKE_NORM;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_i,
  input  stat_t         stat_i,
  input  logic [AW-1:0] addr_i,
  output stat_t         stat_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      addr_o <= '0;
    end else if (save_i) begin
      stat_o <= stat_i;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] FAST_VEC = AW'('h1C),
  parameter logic [AW-1:0] NORM_VEC = AW'('h18)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_req_i,
  input  logic          norm_req_i,
  input  logic          boundary_i,
  input  logic          eret_i,
  input  logic [AW-1:0] pc_i,
  output logic          take_o,
  output logic [AW-1:0] vector_o,
  output logic [AW-1:0] ret_addr_o,
  output logic [1:0]    cur_mode_o,
  output logic          cur_fmask_o,
  output logic          cur_nmask_o,
  output logic [1:0]    sav_mode_o,
  output logic          sav_fmask_o,
  output logic          sav_nmask_o
);
  localparam int SELW = (NBANK > 1) ? $clog2(NBANK) : 1;

  stat_t             cur_q, cur_d;
  logic              eval_q;
  logic [AW-1:0]     resume_q;
  logic              eval;
  logic [AW-1:0]     entry_addr;
  take_e             pick;
  logic [NBANK-1:0]  save;
  stat_t             bank_stat [NBANK];
  logic [AW-1:0]     bank_addr [NBANK];
  logic [SELW-1:0]   bsel;

  // return has precedence; the cycle after it evaluates on its own
  assign eval       = !eret_i && (eval_q || boundary_i);
  assign entry_addr = eval_q ? resume_q : pc_i;

  irq_pick u_pick (
    .eval_i     (eval),
    .fast_req_i (fast_req_i),
    .norm_req_i (norm_req_i),
    .cur_i      (cur_q),
    .pick_o     (pick)
  );

  always_comb begin
    save            = '0;
    save[BANK_FAST] = (pick == TAKE_FAST);
    save[BANK_NORM] = (pick == TAKE_NORM);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_bank #(.AW(AW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .save_i (save[b]),
      .stat_i (cur_q),
      .addr_i (entry_addr),
      .stat_o (bank_stat[b]),
      .addr_o (bank_addr[b])
    );
  end

  assign bsel = (cur_q.mode == MODE_FAST) ? SELW'(BANK_FAST) : SELW'(BANK_NORM);

  always_comb begin
    cur_d = cur_q;
    unique case (pick)
      TAKE_FAST: cur_d = '{mode: MODE_FAST, fmask: 1'b1, nmask: 1'b1};
      TAKE_NORM: cur_d = '{mode: MODE_NORM, fmask: cur_q.fmask, nmask: 1'b1};
      default:   if (eret_i) cur_d = bank_stat[bsel];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= RESET_STAT;
      eval_q   <= 1'b0;
      resume_q <= '0;
      take_o   <= 1'b0;
      vector_o <= '0;
    end else begin
      cur_q  <= cur_d;
      eval_q <= eret_i;
      take_o <= (pick != TAKE_NONE);
      if (eret_i)            resume_q <= bank_addr[bsel];
      if (pick == TAKE_FAST) vector_o <= FAST_VEC;
      if (pick == TAKE_NORM) vector_o <= NORM_VEC;
    end
  end

  assign cur_mode_o  = cur_q.mode;
  assign cur_fmask_o = cur_q.fmask;
  assign cur_nmask_o = cur_q.nmask;
  assign sav_mode_o  = bank_stat[bsel].mode;
  assign sav_fmask_o = bank_stat[bsel].fmask;
  assign sav_nmask_o = bank_stat[bsel].nmask;
  assign ret_addr_o  = bank_addr[bsel];
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] FAST_VEC = AW'('h1C),
  parameter logic [AW-1:0] NORM_VEC = AW'('h18)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fast_req_i,
  input logic          norm_req_i,
  input logic          boundary_i,
  input logic          eret_i,
  input logic          eval_q_i,
  input logic          take_o,
  input logic [AW-1:0] vector_o,
  input logic [1:0]    cur_mode_o,
  input logic          cur_fmask_o,
  input logic          cur_nmask_o,
  input logic [1:0]    sav_mode_o,
  input logic          sav_fmask_o,
  input logic          sav_nmask_o
);
  assert_boundary_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (($past(boundary_i) && !$past(eret_i)) || $past(eval_q_i)));

  assert_fast_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cur_mode_o == 2'd1) |-> (!$past(cur_fmask_o) && $past(fast_req_i)));

  assert_norm_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cur_mode_o == 2'd2) |-> (!$past(cur_nmask_o) && $past(norm_req_i)));

  assert_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((cur_mode_o == 2'd1 && vector_o == FAST_VEC) ||
                (cur_mode_o == 2'd2 && vector_o == NORM_VEC)));

  assert_fast_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cur_mode_o == 2'd1) |-> (cur_fmask_o && cur_nmask_o));

  assert_norm_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cur_mode_o == 2'd2) |-> (cur_nmask_o && cur_fmask_o == $past(cur_fmask_o)));

  assert_eret_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i |=> ({cur_mode_o, cur_fmask_o, cur_nmask_o} ==
                $past({sav_mode_o, sav_fmask_o, sav_nmask_o})));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .AW(AW), .FAST_VEC(FAST_VEC), .NORM_VEC(NORM_VEC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fast_req_i  (fast_req_i),
  .norm_req_i  (norm_req_i),
  .boundary_i  (boundary_i),
  .eret_i      (eret_i),
  .eval_q_i    (eval_q),
  .take_o      (take_o),
  .vector_o    (vector_o),
  .cur_mode_o  (cur_mode_o),
  .cur_fmask_o (cur_fmask_o),
  .cur_nmask_o (cur_nmask_o),
  .sav_mode_o  (sav_mode_o),
  .sav_fmask_o (sav_fmask_o),
  .sav_nmask_o (sav_nmask_o)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fast_req_i = 1'b0;
  logic          norm_req_i = 1'b0;
  logic          boundary_i = 1'b0;
  logic          eret_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          take_o;
  logic [AW-1:0] vector_o, ret_addr_o;
  logic [1:0]    cur_mode_o, sav_mode_o;
  logic          cur_fmask_o, cur_nmask_o, sav_fmask_o, sav_nmask_o;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic [AW-1:0] vec;
    logic [AW-1:0] ret;
    logic [1:0]    mode;
    logic          f;
    logic          n;
    logic [1:0]    smode;
    logic          sf;
    logic          sn;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  always #4 clk_i = ~clk_i;

  irq_entry_seq uut (.*);

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, logic [AW-1:0] vec, logic [AW-1:0] ret, logic [1:0] mode,
                      logic f, logic n, logic [1:0] smode, logic sf, logic sn);
    exp_q.push_back('{vec, ret, mode, f, n, smode, sf, sn});
    tag_q.push_back(tag);
  endtask

  // monitor: every take pulse must match the head of the queue
  always @(negedge clk_i) begin
    if (rst_ni && take_o) begin
      if (exp_q.size() == 0) begin
        chk("unexpected take", 1, 0);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " vector"}, vector_o, e.vec);
        chk({t, " ret"}, ret_addr_o, e.ret);
        chk({t, " mode"}, AW'(cur_mode_o), AW'(e.mode));
        chk({t, " fmask"}, AW'(cur_fmask_o), AW'(e.f));
        chk({t, " nmask"}, AW'(cur_nmask_o), AW'(e.n));
        chk({t, " sav mode"}, AW'(sav_mode_o), AW'(e.smode));
        chk({t, " sav masks"}, AW'({sav_fmask_o, sav_nmask_o}), AW'({e.sf, e.sn}));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic bound(logic [AW-1:0] pc);
    boundary_i = 1'b1;
    pc_i = pc;
    step(1);
    boundary_i = 1'b0;
  endtask

  task automatic do_eret();
    eret_i = 1'b1;
    step(1);
    eret_i = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 mode", AW'(cur_mode_o), 3);
    chk("R1 masks", AW'({cur_fmask_o, cur_nmask_o}), 3);
    chk("R1 sav mode", AW'(sav_mode_o), 0);
    chk("R1 sav masks", AW'({sav_fmask_o, sav_nmask_o}), 0);
    chk("R1 ret", ret_addr_o, 0);
    chk("R1 take", AW'(take_o), 0);

    // R3: masked at reset, fast request ignored
    fast_req_i = 1'b1;
    bound(32'h40);
    chk("R3 masked fast", AW'(take_o), 0);
    fast_req_i = 1'b0;

    // R7: return restores cleared normal bank -> user, unmasked
    do_eret();
    chk("R7 mode", AW'(cur_mode_o), 0);
    chk("R7 masks", AW'({cur_fmask_o, cur_nmask_o}), 0);
    step(1);

    // R2: pending request with no boundary
    norm_req_i = 1'b1;
    step(3);
    chk("R2 no boundary", AW'(take_o), 0);
    // R10: request drops before evaluation point
    norm_req_i = 1'b0;
    bound(32'h80);
    chk("R10 dropped req", AW'(take_o), 0);
    chk("R10 mode", AW'(cur_mode_o), 0);

    // R6: normal entry
    norm_req_i = 1'b1;
    push("R6 norm entry", 32'h18, 32'h100, 2, 0, 1, 0, 0, 0);
    bound(32'h100);
    chk("R6 take", AW'(take_o), 1);
    norm_req_i = 1'b0;
    step(1);
    chk("R5 single pulse", AW'(take_o), 0);

    // R9: fast preempts normal handler
    fast_req_i = 1'b1;
    push("R9 fast in norm", 32'h1C, 32'h204, 1, 1, 1, 2, 0, 1);
    bound(32'h204);
    chk("R5 take", AW'(take_o), 1);
    fast_req_i = 1'b0;
    step(1);
    do_eret();
    chk("R9 back to norm mode", AW'(cur_mode_o), 2);
    chk("R9 norm masks", AW'({cur_fmask_o, cur_nmask_o}), 1);
    chk("R9 norm ret kept", ret_addr_o, 32'h100);
    step(2);
    do_eret();
    chk("R9 back to user", AW'(cur_mode_o), 0);
    chk("R9 user masks", AW'({cur_fmask_o, cur_nmask_o}), 0);
    step(2);

    // R4: both pending, fast wins
    fast_req_i = 1'b1;
    norm_req_i = 1'b1;
    push("R4 fast first", 32'h1C, 32'h300, 1, 1, 1, 0, 0, 0);
    bound(32'h300);
    fast_req_i = 1'b0;
    step(1);
    // R3: normal held off inside fast handler
    bound(32'h308);
    chk("R3 norm masked in fast", AW'(take_o), 0);
    // R8: taken right after return, no boundary
    push("R8 norm after eret", 32'h18, 32'h300, 2, 0, 1, 0, 0, 0);
    do_eret();
    chk("R7 restore user", AW'(cur_mode_o), 0);
    chk("R8 not yet", AW'(take_o), 0);
    step(1);
    chk("R8 take after eret", AW'(take_o), 1);
    norm_req_i = 1'b0;
    step(1);
    do_eret();
    step(1);
    chk("R8 resume mode", AW'(cur_mode_o), 0);
    chk("R8 first address", ret_addr_o, 32'h300);
    chk("R8 no extra take", AW'(take_o), 0);

    // R11: boundary coinciding with return is deferred
    norm_req_i = 1'b1;
    push("R11 deferred", 32'h18, 32'h300, 2, 0, 1, 0, 0, 0);
    boundary_i = 1'b1;
    eret_i = 1'b1;
    pc_i = 32'h400;
    step(1);
    boundary_i = 1'b0;
    eret_i = 1'b0;
    chk("R11 no take with eret", AW'(take_o), 0);
    step(1);
    chk("R11 take next cycle", AW'(take_o), 1);
    norm_req_i = 1'b0;
    step(3);

    chk("scoreboard drained", AW'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule